// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel bytes into a serial NRZ line. Software writes a byte, and optionally a ninth bit, into a holding register. When the shifter is idle, the byte moves in one clock cycle into a hidden shift register that sends the frame. A second byte can therefore be written while the first one is still on the line.

A programmable divider sets the bit timing. It produces a baud tick every `divisor + 1` clocks. Each serial bit lasts 16 ticks or 64 ticks, chosen by a speed-select input.

Two indications go back to software:
- A holding-register-empty flag, which is also gated by an interrupt enable to form `irq`. Only a new write clears this flag.
- A polled shift-register-empty status bit.

Top module: `sertx_dbuf`

## Requirements
- R1: A frame is a start bit at 0, then the data bits with bit 0 first, then a stop bit at 1. The line sits at 1 whenever no frame is being sent.
- R2: With `mode9` = 1 the frame has 11 bits, and the ninth data bit comes right after data bit 7. Its value is `wr_bit9` as captured at the write, not its later value. With `mode9` = 0 the frame has 10 bits.
- R3: Every bit, the start and stop bits included, lasts exactly `OVS * (divisor + 1)` clocks, where OVS is 16 when `fast` = 1 and 64 when `fast` = 0. The start bit begins in the clock right after the transfer into the shifter.
- R4: The shifter takes a pending byte only after the stop bit of the current frame has run its full length. The next start bit then begins one clock after that stop bit ends.
- R5: A write sampled at clock edge k reaches the shifter at edge k+1 if the shifter is idle. `hold_flag` is low after edge k and high again after edge k+1.
- R6: Only an accepted write clears `hold_flag`. The flag stays low for the whole time a byte is pending. `irq` equals `hold_flag` AND `irq_en`, and `irq_en` has no effect on the flag.
- R7: While `tx_en` = 0, `hold_flag` is 0, writes are ignored and any pending byte is discarded. Raising `tx_en` with no write makes `hold_flag` 1 at once.
- R8: `shift_empty` is 1 exactly when the shifter holds no frame, from reset onward.
- R9: A second write while a byte is pending replaces that byte. Only the latest byte is sent.
- R10: With `port_en` = 0 the line is 1, a frame in progress is dropped after one clock edge, and no pending byte is transferred. The pending byte is sent once the port is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmit enable |
| mode9 | input | 1 | 1 = nine data bits per frame |
| fast | input | 1 | 1 = 16 ticks per bit, 0 = 64 ticks per bit |
| divisor | input | 8 | Baud divider; tick period is divisor+1 clocks |
| wr_stb | input | 1 | Holding-register write strobe |
| wr_data | input | 8 | Byte to send |
| wr_bit9 | input | 1 | Ninth data bit, captured with the byte |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial line |
| hold_flag | output | 1 | Holding register empty flag |
| irq | output | 1 | Interrupt request |
| shift_empty | output | 1 | Shift register empty status |

## Verification
Faults in the baud counter or the per-bit tick counter change where bit edges fall, so the bench checks the first and last clock of every bit. A wrong count therefore shows on `txd` within the first bit of the first frame. A faulty frame-length counter shows as a missing or extra bit at the stop position, and as `shift_empty` returning early or late at the frame end. Wrong holding-register state shows either as a wrong byte in the next frame or as `hold_flag` reading wrong in the clock after a write or a transfer.

// File: rtl/sertx_dbuf.sv
module sertx_dbuf #(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 8,
  parameter int FAST_OVS = 16,
  parameter int SLOW_OVS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             tx_en,
  input  logic             mode9,
  input  logic             fast,
  input  logic [DIV_W-1:0] divisor,
  input  logic             wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic             wr_bit9,
  input  logic             irq_en,
  output logic             txd,
  output logic             hold_flag,
  output logic             irq,
  output logic             shift_empty
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int OVS_W   = $clog2(SLOW_OVS > FAST_OVS ? SLOW_OVS : FAST_OVS);
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [OVS_W-1:0] FAST_LAST = OVS_W'(FAST_OVS - 1);
  localparam logic [OVS_W-1:0] SLOW_LAST = OVS_W'(SLOW_OVS - 1);

  logic [DIV_W-1:0]   baud_cnt;
  logic [OVS_W-1:0]   ovs_cnt;
  logic               hold_full;
  logic [DATA_W:0]    hold_q;
  logic               busy;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   bits_left;

  wire tick    = (baud_cnt == '0);
  wire [OVS_W-1:0] ovs_last = fast ? FAST_LAST : SLOW_LAST;
  wire bit_end = busy && tick && (ovs_cnt == ovs_last);
  wire load    = port_en && tx_en && hold_full && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)            baud_cnt <= '0;
    else if (load || tick) baud_cnt <= divisor;
    else                   baud_cnt <= baud_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || load)    ovs_cnt <= '0;
    else if (busy && tick) ovs_cnt <= (ovs_cnt == ovs_last) ? '0 : ovs_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (wr_stb) begin
      hold_full <= 1'b1;
      hold_q    <= {wr_bit9, wr_data};
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sh_q      <= '1;
      bits_left <= '0;
    end else if (!port_en) begin
      busy      <= 1'b0;
    end else if (load) begin
      busy      <= 1'b1;
      sh_q      <= {1'b1, mode9 ? hold_q[DATA_W] : 1'b1, hold_q[DATA_W-1:0], 1'b0};
      bits_left <= mode9 ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
    end else if (bit_end) begin
      sh_q      <= {1'b1, sh_q[FRAME_W-1:1]};
      bits_left <= bits_left - 1'b1;
      if (bits_left == CNT_W'(1)) busy <= 1'b0;
    end
  end

  assign txd         = !port_en || !busy || sh_q[0];
  assign hold_flag   = tx_en && !hold_full;
  assign irq         = hold_flag && irq_en;
  assign shift_empty = !busy;

  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!txd || !port_en));
  p_tick_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor != '0 && !load) |=> !tick);
  p_bit_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end && port_en) |=> ($stable(txd) || !port_en));
  p_no_early_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bits_left > CNT_W'(1) && port_en) |=> (busy || !port_en));
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && tx_en) |=> !hold_flag);
  p_enable_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en) && !wr_stb) |-> hold_flag);
  p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> shift_empty);
endmodule

// File: tb/sertx_dbuf_bench.sv
module sertx_dbuf_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, port_en, tx_en, mode9, fast, wr_stb, wr_bit9, irq_en;
  logic [7:0] divisor, wr_data;
  logic       txd, hold_flag, irq, shift_empty;

  sertx_dbuf u_sertx_dbuf (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en), .mode9(mode9),
    .fast(fast), .divisor(divisor), .wr_stb(wr_stb), .wr_data(wr_data),
    .wr_bit9(wr_bit9), .irq_en(irq_en), .txd(txd), .hold_flag(hold_flag),
    .irq(irq), .shift_empty(shift_empty));

  int n_chk = 0, n_fail = 0, L = 16;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic b9);
    @(negedge clk); wr_stb = 1'b1; wr_data = d; wr_bit9 = b9;
    @(posedge clk);
    @(negedge clk); wr_stb = 1'b0;
  endtask

  // called just after the transfer edge
  task automatic frame_check(input logic [7:0] d, input logic b9, input logic m9);
    int nb = m9 ? 11 : 10;
    for (int j = 0; j < nb; j++) begin
      logic e;
      if (j == 0) e = 1'b0;
      else if (j <= 8) e = d[j-1];
      else if (j == 9 && m9) e = b9;
      else e = 1'b1;
      for (int c = 0; c < L; c++) begin
        @(negedge clk);
        if (c == 0 || c == L - 1) chk((j == 9 && m9) ? "R2 ninth bit" : "R1/R3 bit", txd, e);
        @(posedge clk);
      end
    end
    @(negedge clk);
    chk("R8 empty after stop", shift_empty, 1);
    chk("R4 idle gap high", txd, 1);
  endtask

  task automatic send(input logic [7:0] d, input logic b9);
    put(d, b9);
    wr_bit9 = ~b9;
    chk("R5 flag low after write", hold_flag, 0);
    chk("R8 empty before transfer", shift_empty, 1);
    @(posedge clk);
    frame_check(d, b9, mode9);
    chk("R5 flag set after transfer", hold_flag, 1);
    chk("R6 irq gated", irq, irq_en);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      summary;
      $finish;
    end
  end

  initial begin
    rst_n = 0; port_en = 0; tx_en = 0; mode9 = 0; fast = 1; divisor = 0;
    wr_stb = 0; wr_data = 0; wr_bit9 = 0; irq_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset line high", txd, 1);
    chk("R8 reset empty", shift_empty, 1);
    chk("R7 reset flag low", hold_flag, 0);
    rst_n = 1; port_en = 1;

    // R7: write while transmit disabled is ignored
    put(8'h3C, 1'b0);
    repeat (5) @(negedge clk);
    chk("R7 no frame when disabled", txd, 1);
    chk("R7 flag low when disabled", hold_flag, 0);
    tx_en = 1'b1; #1;
    chk("R7 enable sets flag", hold_flag, 1);
    repeat (40) @(negedge clk);
    chk("R7 discarded write not sent", txd, 1);
    chk("R7 shifter stays empty", shift_empty, 1);
    chk("R6 irq off when disabled", irq, 0);
    irq_en = 1'b1; #1;
    chk("R6 irq follows enable", irq, 1);
    chk("R6 enable leaves flag", hold_flag, 1);

    // sweep of speed and divider settings
    for (int cfg = 0; cfg < 5; cfg++) begin
      @(negedge clk);
      fast    = (cfg < 3);
      divisor = (cfg < 3) ? 8'(cfg) : 8'(cfg - 3);
      L = (fast ? 16 : 64) * (int'(divisor) + 1);
      for (int p = 0; p < 8; p++) begin
        logic [7:0] d;
        case (p % 4)
          0: d = 8'h01;
          1: d = 8'hA5;
          2: d = 8'h5A;
          default: d = 8'hFE;
        endcase
        mode9 = (p >= 4);
        send(d, ~^d);
      end
    end

    // R4/R9: writes during a frame, the later write replaces the earlier
    @(negedge clk); fast = 1; divisor = 8'd1; mode9 = 0; L = 32;
    put(8'h96, 1'b0);
    @(posedge clk);
    fork
      frame_check(8'h96, 1'b0, 1'b0);
      begin
        repeat (3) @(negedge clk);
        wr_stb = 1'b1; wr_data = 8'h11; wr_bit9 = 1'b0;
        @(posedge clk);
        @(negedge clk); wr_stb = 1'b0;
        chk("R6 flag low while pending", hold_flag, 0);
        repeat (4) @(negedge clk);
        wr_stb = 1'b1; wr_data = 8'hC3;
        @(posedge clk);
        @(negedge clk); wr_stb = 1'b0;
        repeat (50) @(negedge clk);
        chk("R6 flag held low mid frame", hold_flag, 0);
      end
    join
    chk("R4 pending stays after stop", hold_flag, 0);
    @(posedge clk);
    frame_check(8'hC3, 1'b0, 1'b0);
    chk("R9 flag after overwritten byte sent", hold_flag, 1);

    // R10: port disable aborts a frame and blocks transfer
    put(8'h00, 1'b0);
    @(posedge clk);
    repeat (20) @(negedge clk);
    port_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 line high on disable", txd, 1);
    chk("R10 frame dropped", shift_empty, 1);
    put(8'h81, 1'b0);
    repeat (10) @(negedge clk);
    chk("R10 no transfer while disabled", shift_empty, 1);
    chk("R10 line idle while disabled", txd, 1);
    chk("R10 byte still pending", hold_flag, 0);
    port_en = 1'b1;
    @(posedge clk);
    frame_check(8'h81, 1'b0, 1'b0);

    done = 1;
    summary;
    $finish;
  end
endmodule